// File: doc/BRIEF.md
# Data Eye Window Centering Engine

This block takes the per-bit edge results of a delay-line search for one byte lane and turns them into a single centred delay tap. A run opens with a start strobe. The caller then presents one result set per training pattern. Each set holds eight start taps from the upward search, eight end taps from the downward search, and one lock flag per search direction. A finish strobe closes the run. On every pattern the engine narrows a running lane window. The lane start rises to the largest per-bit start and the lane end falls to the smallest per-bit end. The engine then checks the narrowed window and records whether the lane has failed.

At the finish the engine sorts the lane into one of four states. For a usable lane it reports the centre tap and a 5-bit window length. In write mode all taps carry a fixed bias of 64. That bias is added to the starting lane end and removed again from the centre. An optional halt setting ends the run at the first window that fails its check. The engine does not run the search and does not program any PHY register. It only consumes edges and produces the values that software or a sequencer writes back.

Top module: `cen_eye_center`

## Requirements
- R1: A start strobe sets the lane start to 0 and the lane end to (maximum size − 1 + bias). The bias is 64 in write mode (mode_wr_i = 1) and 0 in read mode. The maximum size is WIN_MAX_WR or WIN_MAX_RD for the selected mode. A finish with no pattern in between therefore reports centre ((max − 1 + bias) >> 1) − bias, taken modulo 128.
- R2: Bit i of each tap bus lies at [7i+6:7i]. On each accepted pattern the lane start becomes the maximum of its old value and all eight start taps. The lane end becomes the minimum of its old value and all eight end taps. This narrowing carries across patterns.
- R3: When either lock flag is low, each bit is judged on its own. A bit whose start is above 0 and whose end is 0 has its end replaced by (maximum size − 1). Any other bit marks the lane failed and leaves its window untouched.
- R4: Once the lane has failed, a later pattern with a lock flag low is ignored and the lane stays failed.
- R5: After each update the window passes if either of two tests holds. The length test is start + WIN_MIN < end + 1 < start + maximum size. The boundary test is (start = 0 and end ≠ 0) or (start ≠ max − 1 and end = max − 1). A window that passes neither test marks the lane failed.
- R6: When halt_on_fail_i is 1 at start, a window that fails R5 ends the run. done_o pulses in the following cycle with the failed result, and later pattern and finish strobes are ignored until the next start.
- R7: State encoding: 0 good, 1 failed, 2 high-edge, 3 low-edge. A lane that has not failed gets state 3 if its start is 0 and 2 < end − start < WIN_MIN. Otherwise it gets state 2 if its end is max − 1 and the same span condition holds. Otherwise it gets state 0.
- R8: For a lane in state 0, 2 or 3, center_o = ((end + start) >> 1) − bias modulo 128, and win_len_o = (end − start + 1) modulo 32, with fail_o = 0. A failed lane reports center 0, length 0, state 1 and fail_o = 1.
- R9: done_o is high for exactly one cycle, in the cycle after finish_i is sampled. The result outputs hold their values until the next done_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Opens a run and latches mode and halt setting |
| mode_wr_i | input | 1 | 1 = write mode (bias 64), 0 = read mode |
| halt_on_fail_i | input | 1 | End the run on the first failed window check |
| pat_valid_i | input | 1 | One pattern's edge results are valid |
| beg_taps_i | input | 56 | Eight 7-bit start taps, bit i at [7i+6:7i] |
| end_taps_i | input | 56 | Eight 7-bit end taps, same layout |
| lock_up_i | input | 1 | Upward search locked |
| lock_dn_i | input | 1 | Downward search locked |
| finish_i | input | 1 | Closes the run and requests the result |
| done_o | output | 1 | One-cycle result strobe |
| center_o | output | 7 | Centred delay tap |
| win_len_o | output | 5 | Lane window length |
| state_o | output | 2 | Lane state (0 good, 1 failed, 2 high-edge, 3 low-edge) |
| fail_o | output | 1 | Lane failed |

## Verification
Single-pattern runs cover four cases: a locked lane with uneven per-bit edges, a biased write-mode lane, a lock failure that the end fix-up rescues, and a lock failure that it does not rescue. Together these separate the max/min reduction, the bias path and the fix-up rule. Windows that hug the top or bottom tap exercise the two false-lock states and the boundary escape of the validity check. A window that spans the full range shows the 5-bit length wrap. A three-pattern run shows that the narrowing keeps earlier extremes. Empty runs in both modes expose the initial bounds and the bias removal applied to an end beyond the range. Halt and skip sequences show that a failed lane stays failed and that an aborted run ignores its finish.

// File: rtl/cen_eye_pkg.sv
package cen_eye_pkg;
  typedef enum logic [1:0] {
    LS_OK      = 2'd0,
    LS_FAIL    = 2'd1,
    LS_HI_EDGE = 2'd2,
    LS_LO_EDGE = 2'd3
  } lane_state_e;
endpackage

// File: rtl/cen_lane_reduce.sv
module cen_lane_reduce #(
  parameter int NB = 8,
  parameter int TW = 7
) (
  input  logic [NB*TW-1:0] beg_i,
  input  logic [NB*TW-1:0] end_i,
  input  logic             locked_i,
  input  logic [TW-1:0]    top_i,
  output logic [TW-1:0]    beg_max_o,
  output logic [TW-1:0]    end_min_o,
  output logic             any_bad_o
);
  logic [TW-1:0] beg_v [NB];
  logic [TW-1:0] end_v [NB];
  logic [NB-1:0] bad_v;

  for (genvar i = 0; i < NB; i++) begin : g_bit
    logic fixable;
    assign fixable  = (beg_i[i*TW +: TW] != '0) && (end_i[i*TW +: TW] == '0);
    assign beg_v[i] = beg_i[i*TW +: TW];
    // unlocked bit with a lost end edge: pin end to the top tap
    assign end_v[i] = (!locked_i && fixable) ? top_i : end_i[i*TW +: TW];
    assign bad_v[i] = !locked_i && !fixable;
  end

  always_comb begin
    beg_max_o = '0;
    end_min_o = '1;
    for (int i = 0; i < NB; i++) begin
      if (beg_v[i] > beg_max_o) beg_max_o = beg_v[i];
      if (end_v[i] < end_min_o) end_min_o = end_v[i];
    end
  end

  assign any_bad_o = |bad_v;
endmodule

// File: rtl/cen_win_check.sv
module cen_win_check #(
  parameter int TW      = 7,
  parameter int WIN_MIN = 8
) (
  input  logic [TW-1:0] beg_i,
  input  logic [TW-1:0] end_i,
  input  logic [TW-1:0] top_i,
  output logic          ok_o
);
  localparam int XW = TW + 2;
  localparam logic [XW-1:0] MIN_X = XW'(WIN_MIN);

  logic [XW-1:0] e1, b_x, t_x;
  logic len_ok, edge_ok;

  assign e1  = {2'b00, end_i} + XW'(1);
  assign b_x = {2'b00, beg_i};
  assign t_x = {2'b00, top_i};

  assign len_ok  = (e1 > b_x + MIN_X) && (e1 < b_x + t_x + XW'(1));
  assign edge_ok = ((beg_i == '0) && (end_i != '0)) ||
                   ((beg_i != top_i) && (end_i == top_i));
  assign ok_o    = len_ok || edge_ok;
endmodule

// File: rtl/cen_finalize.sv
module cen_finalize
  import cen_eye_pkg::*;
#(
  parameter int TW      = 7,
  parameter int WIN_MIN = 8
) (
  input  logic [TW-1:0] beg_i,
  input  logic [TW-1:0] end_i,
  input  logic [TW-1:0] top_i,
  input  logic [TW-1:0] bias_i,
  input  logic          failed_i,
  output logic [TW-1:0] center_o,
  output logic [4:0]    len_o,
  output lane_state_e   state_o,
  output logic          fail_o
);
  logic [TW:0]        sum;
  logic signed [TW:0] diff;
  logic               span_mid;
  logic [TW-1:0]      len_full;

  assign sum      = {1'b0, end_i} + {1'b0, beg_i};
  assign diff     = $signed({1'b0, end_i}) - $signed({1'b0, beg_i});
  assign span_mid = (diff > 2) && (diff < (TW+1)'(WIN_MIN));
  assign len_full = end_i - beg_i + TW'(1);

  always_comb begin
    center_o = '0;
    len_o    = '0;
    state_o  = LS_FAIL;
    fail_o   = 1'b1;
    if (!failed_i) begin
      fail_o   = 1'b0;
      center_o = sum[TW:1] - bias_i;
      len_o    = len_full[4:0];
      if (span_mid && beg_i == '0)       state_o = LS_LO_EDGE;
      else if (span_mid && end_i == top_i) state_o = LS_HI_EDGE;
      else                                 state_o = LS_OK;
    end
  end
endmodule

// File: rtl/cen_eye_center.sv
module cen_eye_center
  import cen_eye_pkg::*;
#(
  parameter int NB         = 8,
  parameter int TW         = 7,
  parameter int WIN_MAX_RD = 32,
  parameter int WIN_MAX_WR = 32,
  parameter int WIN_MIN    = 8,
  parameter int WR_BIAS    = 64
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             mode_wr_i,
  input  logic             halt_on_fail_i,
  input  logic             pat_valid_i,
  input  logic [NB*TW-1:0] beg_taps_i,
  input  logic [NB*TW-1:0] end_taps_i,
  input  logic             lock_up_i,
  input  logic             lock_dn_i,
  input  logic             finish_i,
  output logic             done_o,
  output logic [TW-1:0]    center_o,
  output logic [4:0]       win_len_o,
  output logic [1:0]       state_o,
  output logic             fail_o
);
  localparam logic [TW-1:0] TOP_RD = TW'(WIN_MAX_RD - 1);
  localparam logic [TW-1:0] TOP_WR = TW'(WIN_MAX_WR - 1);
  localparam logic [TW-1:0] BIAS_W = TW'(WR_BIAS);

  logic          active_q, mode_q, halt_q, failed_q;
  logic [TW-1:0] lane_beg_q, lane_end_q;
  logic [TW-1:0] top_w, bias_w;
  logic          locked;
  logic [TW-1:0] pat_beg_max, pat_end_min, new_beg, new_end;
  logic          any_bad, win_ok;
  logic [TW-1:0] fin_center;
  logic [4:0]    fin_len;
  lane_state_e   fin_state;
  logic          fin_fail;

  assign top_w  = mode_q ? TOP_WR : TOP_RD;
  assign bias_w = mode_q ? BIAS_W : '0;
  assign locked = lock_up_i && lock_dn_i;

  cen_lane_reduce #(.NB(NB), .TW(TW)) u_reduce (
    .beg_i     (beg_taps_i),
    .end_i     (end_taps_i),
    .locked_i  (locked),
    .top_i     (top_w),
    .beg_max_o (pat_beg_max),
    .end_min_o (pat_end_min),
    .any_bad_o (any_bad)
  );

  assign new_beg = (pat_beg_max > lane_beg_q) ? pat_beg_max : lane_beg_q;
  assign new_end = (pat_end_min < lane_end_q) ? pat_end_min : lane_end_q;

  cen_win_check #(.TW(TW), .WIN_MIN(WIN_MIN)) u_check (
    .beg_i (new_beg),
    .end_i (new_end),
    .top_i (top_w),
    .ok_o  (win_ok)
  );

  cen_finalize #(.TW(TW), .WIN_MIN(WIN_MIN)) u_final (
    .beg_i    (lane_beg_q),
    .end_i    (lane_end_q),
    .top_i    (top_w),
    .bias_i   (bias_w),
    .failed_i (failed_q),
    .center_o (fin_center),
    .len_o    (fin_len),
    .state_o  (fin_state),
    .fail_o   (fin_fail)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q   <= 1'b0;
      mode_q     <= 1'b0;
      halt_q     <= 1'b0;
      failed_q   <= 1'b0;
      lane_beg_q <= '0;
      lane_end_q <= '0;
      done_o     <= 1'b0;
      center_o   <= '0;
      win_len_o  <= '0;
      state_o    <= '0;
      fail_o     <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (start_i) begin
        active_q   <= 1'b1;
        mode_q     <= mode_wr_i;
        halt_q     <= halt_on_fail_i;
        failed_q   <= 1'b0;
        lane_beg_q <= '0;
        lane_end_q <= mode_wr_i ? TOP_WR + BIAS_W : TOP_RD;
      end else if (active_q && finish_i) begin
        active_q  <= 1'b0;
        done_o    <= 1'b1;
        center_o  <= fin_center;
        win_len_o <= fin_len;
        state_o   <= fin_state;
        fail_o    <= fin_fail;
      end else if (active_q && pat_valid_i) begin
        if (!locked && failed_q) begin
          // failed lane: unlocked patterns are skipped
        end else if (!locked && any_bad) begin
          failed_q <= 1'b1;
        end else begin
          lane_beg_q <= new_beg;
          lane_end_q <= new_end;
          if (!win_ok) begin
            failed_q <= 1'b1;
            if (halt_q) begin
              active_q  <= 1'b0;
              done_o    <= 1'b1;
              center_o  <= '0;
              win_len_o <= '0;
              state_o   <= LS_FAIL;
              fail_o    <= 1'b1;
            end
          end
        end
      end
    end
  end
endmodule

// File: rtl/cen_eye_center_chk.sv
module cen_eye_center_chk #(
  parameter int TW = 7
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          finish_i,
  input logic          pat_valid_i,
  input logic          mode_q,
  input logic          done_o,
  input logic [TW-1:0] center_o,
  input logic [4:0]    win_len_o,
  input logic [1:0]    state_o,
  input logic          fail_o
);
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R9
  AST_RESULT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> ($stable(center_o) && $stable(state_o) && $stable(win_len_o))); // R9
  AST_DONE_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> ($past(finish_i) || $past(pat_valid_i))); // R6
  AST_FAIL_MATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (fail_o == (state_o == 2'd1))); // R8
  AST_FAIL_ZEROED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && fail_o) |-> (center_o == '0 && win_len_o == '0)); // R8
  AST_LOW_EDGE_CENTER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && state_o == 2'd3 && !mode_q) |-> (center_o == TW'((win_len_o - 5'd1) >> 1))); // R7
endmodule

bind cen_eye_center cen_eye_center_chk #(.TW(TW)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .finish_i    (finish_i),
  .pat_valid_i (pat_valid_i),
  .mode_q      (mode_q),
  .done_o      (done_o),
  .center_o    (center_o),
  .win_len_o   (win_len_o),
  .state_o     (state_o),
  .fail_o      (fail_o)
);

// File: tb/cen_eye_center_tb_top.sv
module cen_eye_center_tb_top;
  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic        wr;
    logic        lu;
    logic        ld;
    logic [55:0] beg;
    logic [55:0] en;
    logic [6:0]  ctr;
    logic [4:0]  len;
    logic [1:0]  st;
    logic        fl;
  } vec_t;

  // bit 7 is the leftmost 7-bit field
  localparam vec_t VEC [8] = '{
    '{1'b0, 1'b1, 1'b1, {7'd5,7'd5,7'd5,7'd5,7'd7,7'd5,7'd5,7'd5},
      {7'd25,7'd22,7'd25,7'd25,7'd25,7'd25,7'd25,7'd25}, 7'd14, 5'd16, 2'd0, 1'b0},
    '{1'b1, 1'b1, 1'b1, {8{7'd70}}, {8{7'd90}}, 7'd16, 5'd21, 2'd0, 1'b0},
    '{1'b0, 1'b0, 1'b1, {8{7'd4}}, {8{7'd0}}, 7'd17, 5'd28, 2'd0, 1'b0},
    '{1'b0, 1'b1, 1'b0, {7'd4,7'd4,7'd4,7'd4,7'd4,7'd0,7'd4,7'd4}, {8{7'd0}}, 7'd0, 5'd0, 2'd1, 1'b1},
    '{1'b0, 1'b1, 1'b1, {8{7'd27}}, {8{7'd31}}, 7'd29, 5'd5, 2'd2, 1'b0},
    '{1'b0, 1'b1, 1'b1, {8{7'd0}}, {8{7'd4}}, 7'd2, 5'd5, 2'd3, 1'b0},
    '{1'b0, 1'b1, 1'b1, {8{7'd10}}, {8{7'd14}}, 7'd0, 5'd0, 2'd1, 1'b1},
    '{1'b0, 1'b1, 1'b1, {8{7'd0}}, {8{7'd31}}, 7'd15, 5'd0, 2'd0, 1'b0}
  };

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0, mode_wr_i = 1'b0, halt_on_fail_i = 1'b0;
  logic        pat_valid_i = 1'b0, lock_up_i = 1'b0, lock_dn_i = 1'b0, finish_i = 1'b0;
  logic [55:0] beg_taps_i = '0, end_taps_i = '0;
  logic        done_o, fail_o;
  logic [6:0]  center_o;
  logic [4:0]  win_len_o;
  logic [1:0]  state_o;

  int errors = 0;
  int checks = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  cen_eye_center dut_i (
    .clk_i, .rst_ni, .start_i, .mode_wr_i, .halt_on_fail_i, .pat_valid_i,
    .beg_taps_i, .end_taps_i, .lock_up_i, .lock_dn_i, .finish_i,
    .done_o, .center_o, .win_len_o, .state_o, .fail_o
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic begin_run(input logic wr, input logic halt);
    @(negedge clk_i);
    start_i = 1'b1; mode_wr_i = wr; halt_on_fail_i = halt;
    @(negedge clk_i);
    start_i = 1'b0;
  endtask

  task automatic send_pat(input logic [55:0] b, input logic [55:0] e,
                          input logic lu, input logic ld);
    pat_valid_i = 1'b1; beg_taps_i = b; end_taps_i = e; lock_up_i = lu; lock_dn_i = ld;
    @(negedge clk_i);
    pat_valid_i = 1'b0;
  endtask

  task automatic end_run();
    finish_i = 1'b1;
    @(negedge clk_i);
    finish_i = 1'b0;
  endtask

  task automatic check_result(input string tag, input int c, input int l,
                              input int s, input int f);
    check({tag, " done"}, int'(done_o), 1);
    check({tag, " center"}, int'(center_o), c);
    check({tag, " len"}, int'(win_len_o), l);
    check({tag, " state"}, int'(state_o), s);
    check({tag, " fail"}, int'(fail_o), f);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check("R9 reset done", int'(done_o), 0);
    check("R9 reset center", int'(center_o), 0);
    check("R9 reset state", int'(state_o), 0);
    check("R9 reset fail", int'(fail_o), 0);

    // R2 R3 R5 R7 R8 single-pattern table
    for (int i = 0; i < 8; i++) begin
      begin_run(VEC[i].wr, 1'b0);
      send_pat(VEC[i].beg, VEC[i].en, VEC[i].lu, VEC[i].ld);
      end_run();
      check_result($sformatf("R8 vec%0d", i), int'(VEC[i].ctr), int'(VEC[i].len),
                   int'(VEC[i].st), int'(VEC[i].fl));
      @(negedge clk_i);
      check($sformatf("R9 vec%0d pulse", i), int'(done_o), 0);
      check($sformatf("R9 vec%0d hold", i), int'(center_o), int'(VEC[i].ctr));
    end

    // R2 narrowing over three patterns: start 6, end 25
    begin_run(1'b0, 1'b0);
    send_pat({8{7'd3}}, {8{7'd28}}, 1'b1, 1'b1);
    send_pat({8{7'd6}}, {8{7'd30}}, 1'b1, 1'b1);
    send_pat({8{7'd2}}, {8{7'd25}}, 1'b1, 1'b1);
    end_run();
    check_result("R2 multi", 15, 20, 0, 0);

    // R1 empty runs: read end 31, write end 95 minus bias
    begin_run(1'b0, 1'b0);
    end_run();
    check_result("R1 empty rd", 15, 0, 0, 0);
    begin_run(1'b1, 1'b0);
    end_run();
    check_result("R1 empty wr", 111, 0, 0, 0);

    // R4 failed lane stays failed, rescuable unlocked pattern skipped
    begin_run(1'b0, 1'b0);
    send_pat({8{7'd0}}, {8{7'd0}}, 1'b0, 1'b1);
    send_pat({8{7'd4}}, {8{7'd0}}, 1'b0, 1'b1);
    end_run();
    check_result("R4 skip", 0, 0, 1, 1);

    // R6 halt on failed window
    begin_run(1'b0, 1'b1);
    send_pat({8{7'd10}}, {8{7'd14}}, 1'b1, 1'b1);
    check_result("R6 abort", 0, 0, 1, 1);
    send_pat({8{7'd3}}, {8{7'd28}}, 1'b1, 1'b1);
    end_run();
    check("R6 finish ignored", int'(done_o), 0);
    begin_run(1'b0, 1'b1);
    send_pat({8{7'd3}}, {8{7'd28}}, 1'b1, 1'b1);
    check("R6 no abort on valid", int'(done_o), 0);
    end_run();
    check_result("R6 rerun", 15, 26, 0, 0);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule